// File: doc/BRIEF.md
# Instruction Phase Scoreboard with Token Allocation

This block keeps the bookkeeping for every in-flight instruction of a hardware functional model that a separate timing model steers. The timing model first takes a token from the block. From then on that token names the instruction in every request. Each request moves the instruction one phase forward: fetch, decode, execute, the optional memory access, local commit, and finally global commit or abort. A per-token phase table rejects any request that arrives out of order. A per-token flag records a memory write that so far only the issuing instruction can see.

Tokens come from a FIFO free list. After reset the list runs in the fill state `FL_INIT`. It writes one token ID per cycle and accepts no traffic. Once all IDs are written it takes the transition `FL_INIT -> FL_RUN` and stays in the run state `FL_RUN` until the next reset. A global commit or an abort sends the token back to the tail of the list. A global commit of an instruction that holds a local store also emits a one-cycle release strobe, which lets the memory side make that write globally visible.

Each token moves through these table states: `ST_FREE -> ST_ISSUED -> ST_FETCHED -> ST_DECODED -> ST_EXECUTED -> (ST_MEMDONE) -> ST_LCOMMITTED -> ST_FREE`. From any state other than `ST_FREE`, an abort returns the token to `ST_FREE`.

Top module: `tps_scoreboard`

## Requirements
- R1: While reset is held, and for 2^TOK_W cycles after it is released, `ph_ready` and `tok_rdy` stay low, `rsp_valid` and `rel_valid` stay low, and `local_store` is all zeros.
- R2: The list first hands out tokens in the order 0, 1, 2 and upward. A freed token joins the tail of the list. `tok_rdy` is low exactly when no token is free, and `tok_id` shows the token that the next grant will hand out.
- R3: A grant (`tok_req` high while `tok_rdy` is high) is possible in every cycle, so back-to-back grants return consecutive list entries.
- R4: The `ph_op` codes are 1 fetch, 2 decode, 3 execute, 4 memory access, 5 local commit, 6 global commit and 7 abort. Code 0 is reserved and always gets an error response.
- R5: A fetch is legal only on an issued token that has not been fetched. Decode must follow fetch, and execute must follow decode. Memory access must follow execute. Local commit must follow execute or memory access, so the memory phase may be skipped. Global commit must follow local commit.
- R6: An illegal request gets `rsp_ok` = 0 and leaves the phase table, the local-store flags and the free list unchanged.
- R7: Each accepted request (`ph_valid` and `ph_ready` high) produces `rsp_valid` in the next cycle, carrying the request's token in `rsp_tok`. `rsp_ok` is 1 exactly for legal requests.
- R8: A legal memory access with `ph_store` = 1 sets `local_store[token]` from the next cycle. A memory access with `ph_store` = 0 leaves the flag clear.
- R9: A legal global commit frees the token. If the token's local-store flag was set, `rel_valid` pulses in the response cycle with `rel_tok` equal to the token, and the flag clears.
- R10: An abort is legal on any token that is not free. It clears that token's local-store flag without a release strobe and returns the token to the free list at the same edge.
- R11: A request naming a free token, including a token that is being granted in that same cycle, gets `rsp_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_req | input | 1 | Request for a new token |
| tok_rdy | output | 1 | A token is free and the block is running |
| tok_id | output | TOK_W | Token that the next grant hands out |
| ph_valid | input | 1 | Phase request valid |
| ph_ready | output | 1 | Phase requests are accepted |
| ph_tok | input | TOK_W | Token that the phase request names |
| ph_op | input | 3 | Phase code (see R4) |
| ph_store | input | 1 | The memory-access phase writes memory |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_tok | output | TOK_W | Token of the response |
| rsp_ok | output | 1 | 1 when the request was legal |
| rel_valid | output | 1 | Strobe that makes a store globally visible |
| rel_tok | output | TOK_W | Token whose store is released |
| local_store | output | 2^TOK_W | Per-token flag for a store visible only locally |

## Verification
The bench builds the block with TOK_W = 3, which gives eight tokens. With so few tokens, random traffic drains the free list often. This exercises the empty-list stall, pushes that wrap at the tail, and grants and frees that land in the same cycle. The fill phase also stays short. A behavioural model built from queues and integer arrays predicts every output on every cycle. Directed sequences cover the skipped memory phase, abort with a pending store, reserved codes, and a request on a token that is granted in the same cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_FETCH   = 3'd1,
        OP_DECODE  = 3'd2,
        OP_EXEC    = 3'd3,
        OP_MEM     = 3'd4,
        OP_LCOMMIT = 3'd5,
        OP_GCOMMIT = 3'd6,
        OP_ABORT   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_FREE       = 3'd0,
        ST_ISSUED     = 3'd1,
        ST_FETCHED    = 3'd2,
        ST_DECODED    = 3'd3,
        ST_EXECUTED   = 3'd4,
        ST_MEMDONE    = 3'd5,
        ST_LCOMMITTED = 3'd6
    } stage_e;

    typedef enum logic {
        FL_INIT = 1'b0,
        FL_RUN  = 1'b1
    } fl_state_e;

endpackage

// File: rtl/tps_free_list.sv
module tps_free_list
    import tps_pkg::*;
#(
    parameter int TOK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TOK_W-1:0] push_id,
    output logic             running,
    output logic             avail,
    output logic [TOK_W-1:0] head_id
);
    localparam int NUM_TOK = 1 << TOK_W;
    localparam logic [TOK_W-1:0] LAST_ID = TOK_W'(NUM_TOK - 1);
    localparam logic [TOK_W:0]   FULL    = (TOK_W+1)'(NUM_TOK);

    fl_state_e        state_q;
    logic [TOK_W-1:0] mem_q [NUM_TOK];
    logic [TOK_W-1:0] head_q, tail_q, fill_q;
    logic [TOK_W:0]   count_q;

    logic             wr_en;
    logic [TOK_W-1:0] wr_idx, wr_data;

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_INIT;
            fill_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            unique case (state_q)
                FL_INIT: begin
                    fill_q <= fill_q + 1'b1;
                    if (fill_q == LAST_ID) begin
                        state_q <= FL_RUN;
                        count_q <= FULL;
                    end
                end
                FL_RUN: begin
                    if (pop)  head_q <= head_q + 1'b1;
                    if (push) tail_q <= tail_q + 1'b1;
                    unique case ({push, pop})
                        2'b10:   count_q <= count_q + 1'b1;
                        2'b01:   count_q <= count_q - 1'b1;
                        default: count_q <= count_q;
                    endcase
                end
            endcase
        end
    end

    // outputs and write port
    always_comb begin
        running = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = tail_q;
        wr_data = push_id;
        unique case (state_q)
            FL_INIT: begin
                wr_en   = 1'b1;
                wr_idx  = fill_q;
                wr_data = fill_q;
            end
            FL_RUN: begin
                running = 1'b1;
                wr_en   = push;
            end
        endcase
        avail   = running && (count_q != '0);
        head_id = mem_q[head_q];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (running && count_q != '0));
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (running && count_q < FULL));

endmodule

// File: rtl/tps_phase_rules.sv
module tps_phase_rules
    import tps_pkg::*;
(
    input  stage_e cur,
    input  op_e    op,
    output logic   legal,
    output stage_e nxt,
    output logic   frees
);
    always_comb begin
        legal = 1'b0;
        nxt   = cur;
        frees = 1'b0;
        unique case (op)
            OP_NONE: legal = 1'b0;
            OP_FETCH: begin
                legal = (cur == ST_ISSUED);
                nxt   = ST_FETCHED;
            end
            OP_DECODE: begin
                legal = (cur == ST_FETCHED);
                nxt   = ST_DECODED;
            end
            OP_EXEC: begin
                legal = (cur == ST_DECODED);
                nxt   = ST_EXECUTED;
            end
            OP_MEM: begin
                legal = (cur == ST_EXECUTED);
                nxt   = ST_MEMDONE;
            end
            OP_LCOMMIT: begin
                legal = (cur == ST_EXECUTED) || (cur == ST_MEMDONE);
                nxt   = ST_LCOMMITTED;
            end
            OP_GCOMMIT: begin
                legal = (cur == ST_LCOMMITTED);
                nxt   = ST_FREE;
                frees = 1'b1;
            end
            OP_ABORT: begin
                legal = (cur != ST_FREE);
                nxt   = ST_FREE;
                frees = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tps_store_flags.sv
module tps_store_flags #(
    parameter int TOK_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic                    clr_en,
    input  logic [TOK_W-1:0]        idx,
    output logic [(1<<TOK_W)-1:0]   flags
);
    localparam int NUM_TOK = 1 << TOK_W;

    for (genvar g = 0; g < NUM_TOK; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   bit_q <= 1'b0;
            else if (set_en && idx == TOK_W'(g))          bit_q <= 1'b1;
            else if (clr_en && idx == TOK_W'(g))          bit_q <= 1'b0;
        end
        assign flags[g] = bit_q;
    end
endmodule

// File: rtl/tps_scoreboard.sv
module tps_scoreboard
    import tps_pkg::*;
#(
    parameter int TOK_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tok_req,
    output logic                  tok_rdy,
    output logic [TOK_W-1:0]      tok_id,
    input  logic                  ph_valid,
    output logic                  ph_ready,
    input  logic [TOK_W-1:0]      ph_tok,
    input  logic [2:0]            ph_op,
    input  logic                  ph_store,
    output logic                  rsp_valid,
    output logic [TOK_W-1:0]      rsp_tok,
    output logic                  rsp_ok,
    output logic                  rel_valid,
    output logic [TOK_W-1:0]      rel_tok,
    output logic [(1<<TOK_W)-1:0] local_store
);
    localparam int NUM_TOK = 1 << TOK_W;

    logic             fl_running, fl_avail, grant, accept, upd;
    logic [TOK_W-1:0] head_id;
    stage_e           stage_q [NUM_TOK];
    stage_e           cur, nxt;
    op_e              op;
    logic             legal, frees;

    assign op       = op_e'(ph_op);
    assign ph_ready = fl_running;
    assign tok_rdy  = fl_avail;
    assign tok_id   = head_id;
    assign grant    = tok_req && fl_avail;
    assign accept   = ph_valid && fl_running;
    assign cur      = stage_q[ph_tok];
    assign upd      = accept && legal;

    tps_free_list #(.TOK_W(TOK_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (grant),
        .push    (upd && frees),
        .push_id (ph_tok),
        .running (fl_running),
        .avail   (fl_avail),
        .head_id (head_id)
    );

    tps_phase_rules u_rules (
        .cur   (cur),
        .op    (op),
        .legal (legal),
        .nxt   (nxt),
        .frees (frees)
    );

    tps_store_flags #(.TOK_W(TOK_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (upd && op == OP_MEM && ph_store),
        .clr_en (upd && (op == OP_GCOMMIT || op == OP_ABORT)),
        .idx    (ph_tok),
        .flags  (local_store)
    );

    // phase table: a grant and a legal update never name the same token
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TOK; i++) stage_q[i] <= ST_FREE;
        end else begin
            for (int i = 0; i < NUM_TOK; i++) begin
                if (grant && head_id == TOK_W'(i))    stage_q[i] <= ST_ISSUED;
                else if (upd && ph_tok == TOK_W'(i))  stage_q[i] <= nxt;
            end
        end
    end

    // response stage, one cycle after acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tok   <= '0;
            rsp_ok    <= 1'b0;
            rel_valid <= 1'b0;
            rel_tok   <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_tok   <= ph_tok;
            rsp_ok    <= accept && legal;
            rel_valid <= upd && op == OP_GCOMMIT && local_store[ph_tok];
            rel_tok   <= ph_tok;
        end
    end

    assert_quiet_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_ready |-> (!tok_rdy && !rsp_valid && local_store == '0));
    assert_error_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> local_store == $past(local_store));
    assert_release_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rsp_valid && rsp_ok && rel_tok == rsp_tok && !local_store[rel_tok]));
    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && $past(ph_op) == 3'd7) |-> (!local_store[rsp_tok] && !rel_valid));

endmodule

// File: tb/tps_scoreboard_test.sv
`timescale 1ns/1ps
module tps_scoreboard_test;
    localparam int TW  = 3;
    localparam int NUM = 1 << TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_req = 1'b0, ph_valid = 1'b0, ph_store = 1'b0;
    logic [TW-1:0] ph_tok = '0;
    logic [2:0] ph_op = '0;
    logic tok_rdy, ph_ready, rsp_valid, rsp_ok, rel_valid;
    logic [TW-1:0] tok_id, rsp_tok, rel_tok;
    logic [NUM-1:0] local_store;

    always #2 clk = ~clk;

    tps_scoreboard #(.TOK_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tok_req(tok_req), .tok_rdy(tok_rdy), .tok_id(tok_id),
        .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_tok(ph_tok), .ph_op(ph_op),
        .ph_store(ph_store), .rsp_valid(rsp_valid), .rsp_tok(rsp_tok), .rsp_ok(rsp_ok),
        .rel_valid(rel_valid), .rel_tok(rel_tok), .local_store(local_store)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: stage 0 free, 1 issued, 2 fetched, 3 decoded, 4 executed, 5 memory, 6 local commit
    int q[$];
    int stg[NUM];
    bit ls[NUM];
    bit running;
    int fill_cnt;
    bit e_rsp_v, e_rsp_ok, e_rel_v;
    int e_rsp_tok, e_rel_tok;
    string ok_tag = "R5";

    function automatic bit is_legal(int op, int s);
        case (op)
            1: return s == 1;
            2: return s == 2;
            3: return s == 3;
            4: return s == 4;
            5: return s == 4 || s == 5;
            6: return s == 6;
            7: return s != 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            foreach (stg[i]) begin stg[i] = 0; ls[i] = 0; end
            running = 0; fill_cnt = 0; e_rsp_v = 0; e_rel_v = 0;
        end else begin
            e_rsp_v = 0; e_rel_v = 0;
            if (!running) begin
                q.push_back(fill_cnt);
                fill_cnt++;
                if (fill_cnt == NUM) running = 1;
            end else begin
                bit do_grant, release_tok;
                int gtok, t, s, op;
                do_grant = tok_req && q.size() > 0;
                gtok = do_grant ? q[0] : -1;
                release_tok = 0;
                if (ph_valid) begin
                    t = int'(ph_tok); op = int'(ph_op); s = stg[t];
                    e_rsp_v = 1; e_rsp_tok = t; e_rsp_ok = is_legal(op, s);
                    if (op == 0) ok_tag = "R4";
                    else if (s == 0) ok_tag = "R11";
                    else if (op == 7) ok_tag = "R10";
                    else if (e_rsp_ok) ok_tag = "R5";
                    else ok_tag = "R6";
                    if (e_rsp_ok) begin
                        case (op)
                            4: begin if (ph_store) ls[t] = 1; stg[t] = 5; end
                            5: stg[t] = 6;
                            6: begin
                                if (ls[t]) begin e_rel_v = 1; e_rel_tok = t; end
                                ls[t] = 0; stg[t] = 0; release_tok = 1;
                            end
                            7: begin ls[t] = 0; stg[t] = 0; release_tok = 1; end
                            default: stg[t] = op + 1;
                        endcase
                    end
                end
                if (do_grant) begin void'(q.pop_front()); stg[gtok] = 1; end
                if (release_tok) q.push_back(t);
            end
        end
    end

    // compare on every clock, 1 ns after the edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            logic [NUM-1:0] ev;
            foreach (ls[i]) ev[i] = ls[i];
            chk(ph_ready === running, "R1 ph_ready", 64'(ph_ready), 64'(running));
            chk(tok_rdy === (running && q.size() > 0), "R2 tok_rdy", 64'(tok_rdy), 64'(running && q.size() > 0));
            if (tok_rdy && q.size() > 0) chk(int'(tok_id) == q[0], "R2 tok_id", 64'(tok_id), 64'(q[0]));
            chk(rsp_valid === e_rsp_v, "R7 rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
            if (e_rsp_v) begin
                chk(int'(rsp_tok) == e_rsp_tok, "R7 rsp_tok", 64'(rsp_tok), 64'(e_rsp_tok));
                chk(rsp_ok === e_rsp_ok, {ok_tag, " rsp_ok"}, 64'(rsp_ok), 64'(e_rsp_ok));
            end
            chk(rel_valid === e_rel_v, "R9 rel_valid", 64'(rel_valid), 64'(e_rel_v));
            if (e_rel_v) chk(int'(rel_tok) == e_rel_tok, "R9 rel_tok", 64'(rel_tok), 64'(e_rel_tok));
            chk(local_store === ev, "R8 local_store", 64'(local_store), 64'(ev));
        end
    end

    task automatic step(input bit req, input bit pv, input int tok, input int op, input bit st);
        @(negedge clk);
        tok_req = req; ph_valid = pv; ph_tok = TW'(tok); ph_op = 3'(op); ph_store = st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int first;
        repeat (3) @(negedge clk);
        chk(tok_rdy === 1'b0 && ph_ready === 1'b0 && local_store === '0, "R1 reset state",
            64'({tok_rdy, ph_ready}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(tok_rdy === 1'b0 && rsp_valid === 1'b0, "R1 fill quiet", 64'(tok_rdy), 64'(0));
        while (!ph_ready) @(negedge clk);

        // back-to-back grants of tokens 0..3
        first = int'(tok_id);
        chk(first == 0, "R2 first token", 64'(first), 64'(0));
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 0, 0);
            chk(int'(tok_id) == i, "R3 consecutive grant", 64'(tok_id), 64'(i));
        end
        idle(1);

        // token 0: full path with a store, then release
        step(0, 1, 0, 1, 0); step(0, 1, 0, 2, 0); step(0, 1, 0, 3, 0);
        step(0, 1, 0, 4, 1); step(0, 1, 0, 5, 0); step(0, 1, 0, 6, 0);
        idle(2);
        // token 1: out-of-order execute, then skip memory
        step(0, 1, 1, 1, 0); step(0, 1, 1, 3, 0); step(0, 1, 1, 2, 0);
        step(0, 1, 1, 3, 0); step(0, 1, 1, 5, 0); step(0, 1, 1, 6, 0);
        idle(2);
        // token 2: store, then abort
        step(0, 1, 2, 1, 0); step(0, 1, 2, 2, 0); step(0, 1, 2, 3, 0);
        step(0, 1, 2, 4, 1); step(0, 1, 2, 7, 0);
        idle(1);
        @(negedge clk);
        chk(local_store[2] === 1'b0, "R10 abort clears store", 64'(local_store), 64'(0));
        // token 3: reserved code, early global commit, memory without store
        step(0, 1, 3, 0, 0); step(0, 1, 3, 6, 0);
        step(0, 1, 3, 1, 0); step(0, 1, 3, 2, 0); step(0, 1, 3, 3, 0); step(0, 1, 3, 4, 0);
        // request on a free token
        step(0, 1, 6, 1, 0);
        idle(2);
        // drain the list, then a request on a token granted in the same cycle
        for (int i = 0; i < NUM + 2; i++) step(1, 0, 0, 0, 0);
        step(0, 1, 3, 7, 0);
        step(1, 1, int'(tok_id), 1, 0);
        idle(2);

        // random traffic guided by the model's stages
        for (int n = 0; n < 4000; n++) begin
            int t, op;
            t = $urandom_range(NUM - 1);
            op = ($urandom_range(9) == 0) ? $urandom_range(7) :
                 (stg[t] == 0) ? 1 :
                 (stg[t] == 4 && $urandom_range(1) == 0) ? 5 :
                 (stg[t] == 5) ? 5 :
                 (stg[t] == 6) ? 6 : stg[t];
            step($urandom_range(2) == 0, $urandom_range(3) != 0, t, op, $urandom_range(1) == 1);
        end
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule